// File: doc/BRIEF.md
# Write-Busy Status Read Responder

This block owns the byte-wide read data path of a paged nonvolatile memory model. When the memory is idle, a qualified read returns the contents of the storage array unchanged. While an internal write period is running, the block answers with end-of-write status instead. The top bit carries the inverted top bit of the most recently written byte. The bit below it flips once for every new read. All lower bits read as zero.

The host polls in either of two ways. It can compare the top bit against the value it wrote, or it can watch the toggling bit until it stops moving. Reads are separated by releasing and reasserting the output enable, the chip enable, or both. The write controller raises the busy flag for the whole write period, even when a protected write was discarded and no array location changes. This block treats both cases the same way. Control strobes are active low and are sampled on the rising clock edge. Read data and the bus drive enable are registered, so they appear one cycle after the strobes that qualify them.

Top module: `wbr_read_responder`

## Requirements
- R1: While reset is held and after it is released, with no read, the drive enable and every data bit are 0. The toggle state starts at 0, so the first busy read after reset shows bit 6 = 1.
- R2: The drive enable is 1 in the cycle after an edge where chip enable and output enable are both low and write enable is high. Otherwise it is 0.
- R3: With busy low, a qualified read returns the array data sampled at the same edge, one cycle later, on all bits.
- R4: With busy high, data bit 7 of a read is the inverse of bit 7 of the last written byte, for any read address.
- R5: With busy high, each new read flips data bit 6. A new read is an edge where the read qualification is true after being false at the previous edge. Holding the strobes through several cycles counts as one read and does not flip the bit. A new read can be started by cycling either output enable or chip enable.
- R6: With busy high, data bits 5 to 0 read as 0.
- R7: Once busy is low, the next qualified read returns true array data on all bits. Reads taken while busy is low do not change the toggle state.
- R8: A new busy period starts its toggle sequence from the value left by the previous busy period.
- R9: Whenever the drive enable is 0, the data output is all zeros.
- R10: While busy, the returned status does not depend on the array data, so a discarded write polls the same way as a real one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| wr_busy | input | 1 | High for the whole internal write period |
| last_wr_poll | input | 1 | Polled bit (bit 7) of the most recently written byte |
| array_data | input | DW | Data read from the storage array at the current address |
| rd_data_o | output | DW | Registered read data |
| rd_drive_o | output | 1 | Registered enable for the tri-state data bus |

## Verification
Idle reads of changing array words show that the data path passes array contents through. Reads with a strobe released, or with write enable low, show that the bus stays undriven and zeroed. Busy reads separated by output-enable pulses, then by chip-enable pulses, then held across several cycles, separate a real new-read detector from one that flips every cycle or never flips. Polled bytes with bit 7 set and clear, together with array data that changes during the busy period, show that the status ignores the array. A busy period that ends in the middle of a held read, followed by idle reads and then a second busy period, shows where the toggle stops and that its value is kept.

// File: rtl/wbr_pkg.sv
package wbr_pkg;

  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_ARRAY  = 2'd1,
    SRC_STATUS = 2'd2
  } rd_src_e;

  // A read is qualified when both selects are low and the write strobe is high.
  function automatic logic read_qualified(input logic ce_n, input logic oe_n,
                                          input logic we_n);
    return !ce_n && !oe_n && we_n;
  endfunction

endpackage

// File: rtl/wbr_read_qual.sv
module wbr_read_qual
  import wbr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  output logic rd_active,
  output logic rd_start,
  output logic drive_o
);

  logic rd_q;

  assign rd_active = read_qualified(ce_n, oe_n, we_n);
  // A new read begins when qualification appears after a gap.
  assign rd_start  = rd_active && !rd_q;
  assign drive_o   = rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= 1'b0;
    else        rd_q <= rd_active;
  end

  // R5: two consecutive read starts are impossible without a gap
  assert_start_needs_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |=> !rd_start);

endmodule

// File: rtl/wbr_toggle.sv
module wbr_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_start,
  input  logic busy,
  output logic tgl_q,
  output logic tgl_next
);

  logic flip;

  assign flip     = rd_start && busy;
  assign tgl_next = tgl_q ^ flip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tgl_q <= 1'b0;
    else        tgl_q <= tgl_next;
  end

  assert_tgl_frozen_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(tgl_q));

  assert_tgl_flips_on_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_start && busy) |=> (tgl_q != $past(tgl_q)));

endmodule

// File: rtl/wbr_data_sel.sv
module wbr_data_sel
  import wbr_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_active,
  input  logic          busy,
  input  logic          tgl_next,
  input  logic          last_poll,
  input  logic [DW-1:0] array_data,
  output logic [DW-1:0] data_o,
  output rd_src_e       src_o
);

  localparam int unsigned POLL_BIT = DW - 1;
  localparam int unsigned TOG_BIT  = DW - 2;
  localparam logic [DW-1:0] STATUS_MASK = (DW'(1) << POLL_BIT) | (DW'(1) << TOG_BIT);

  function automatic logic [DW-1:0] status_word(input logic poll, input logic tgl);
    logic [DW-1:0] w;
    w           = '0;
    w[POLL_BIT] = ~poll;
    w[TOG_BIT]  = tgl;
    return w;
  endfunction

  rd_src_e       src_d;
  logic [DW-1:0] data_d;

  always_comb begin
    if (!rd_active) src_d = SRC_NONE;
    else if (busy)  src_d = SRC_STATUS;
    else            src_d = SRC_ARRAY;
    unique case (src_d)
      SRC_STATUS: data_d = status_word(last_poll, tgl_next);
      SRC_ARRAY:  data_d = array_data;
      default:    data_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o <= '0;
      src_o  <= SRC_NONE;
    end else begin
      data_o <= data_d;
      src_o  <= src_d;
    end
  end

  assert_status_low_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (src_o == SRC_STATUS) |-> ((data_o & ~STATUS_MASK) == '0));

  assert_poll_inverted_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_active && busy) |=> (data_o[POLL_BIT] != $past(last_poll)));

  assert_array_passthru_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_active && !busy) |=> (data_o == $past(array_data)));

endmodule

// File: rtl/wbr_read_responder.sv
module wbr_read_responder
  import wbr_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          wr_busy,
  input  logic          last_wr_poll,
  input  logic [DW-1:0] array_data,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_drive_o
);

  logic    rd_active;
  logic    rd_start;
  logic    tgl_q;
  logic    tgl_next;
  rd_src_e src_q;

  wbr_read_qual u_qual (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .rd_active (rd_active),
    .rd_start  (rd_start),
    .drive_o   (rd_drive_o)
  );

  wbr_toggle u_tgl (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_start (rd_start),
    .busy     (wr_busy),
    .tgl_q    (tgl_q),
    .tgl_next (tgl_next)
  );

  wbr_data_sel #(.DW(DW)) u_sel (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_active  (rd_active),
    .busy       (wr_busy),
    .tgl_next   (tgl_next),
    .last_poll  (last_wr_poll),
    .array_data (array_data),
    .data_o     (rd_data_o),
    .src_o      (src_q)
  );

  assert_quiet_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_drive_o |-> (rd_data_o == '0));

  assert_drive_follows_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n || !we_n) |=> !rd_drive_o);

  assert_src_matches_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_drive_o == (src_q != SRC_NONE));

  assert_status_shows_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (src_q == SRC_STATUS) |-> (rd_data_o[DW-2] == tgl_q));

endmodule

// File: tb/wbr_read_responder_tb.sv
module wbr_read_responder_tb;
  localparam int unsigned DW = 8;

  typedef struct {
    logic          drv;
    logic [DW-1:0] data;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic          wr_busy = 1'b0, last_wr_poll = 1'b0;
  logic [DW-1:0] array_data = '0;
  logic [DW-1:0] rd_data_o;
  logic          rd_drive_o;

  int   checks = 0, errors = 0;
  exp_t sb_q[$];
  logic m_prev_rd = 1'b0, m_tgl = 1'b0;

  always #10 clk = ~clk;

  wbr_read_responder #(.DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .wr_busy(wr_busy), .last_wr_poll(last_wr_poll), .array_data(array_data),
    .rd_data_o(rd_data_o), .rd_drive_o(rd_drive_o)
  );

  task automatic check(input string tag, input logic [DW:0] act, input logic [DW:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual drv/data=%b_%h expected %b_%h", tag,
               act[DW], act[DW-1:0], exp[DW], exp[DW-1:0]);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the expected response.
  task automatic step(input logic c, input logic o, input logic w, input logic b,
                      input logic lp, input logic [DW-1:0] arr, input string tag);
    exp_t e;
    logic rd;
    @(negedge clk);
    ce_n = c; oe_n = o; we_n = w; wr_busy = b; last_wr_poll = lp; array_data = arr;
    rd = !c && !o && w;
    if (rd && !m_prev_rd && b) m_tgl = ~m_tgl;
    m_prev_rd = rd;
    e.drv = rd;
    if (!rd)    e.data = '0;
    else if (b) e.data = {~lp, m_tgl, 6'b0};
    else        e.data = arr;
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  // Monitor: compares the registered outputs just after each edge.
  always @(posedge clk) begin
    if (rst_n) begin
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.tag, {rd_drive_o, rd_data_o}, {e.drv, e.data});
      end
    end
  end

  initial begin
    #(20 * 5000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", {rd_drive_o, rd_data_o}, '0);
    rst_n = 1'b1;
    step(1, 1, 1, 0, 0, 8'h5A, "R1 idle after reset");
    // idle array reads
    step(0, 0, 1, 0, 0, 8'hA5, "R3 idle read");
    step(0, 0, 1, 0, 0, 8'h3C, "R3 held read new word");
    step(0, 1, 1, 0, 0, 8'h3C, "R2 oe high");
    step(1, 0, 1, 0, 0, 8'hFF, "R2 ce high");
    step(0, 0, 0, 0, 0, 8'hFF, "R9 we low no drive");
    step(0, 0, 1, 0, 1, 8'h81, "R3 read");
    step(1, 1, 1, 0, 1, 8'h81, "R9 quiet");
    // busy period 1, polled bit 1 -> bit7 reads 0
    step(1, 1, 1, 1, 1, 8'h11, "R9 busy no read");
    step(0, 0, 1, 1, 1, 8'h11, "R4 R5 R6 first busy read");
    step(0, 1, 1, 1, 1, 8'h22, "R9 gap");
    step(0, 0, 1, 1, 1, 8'h33, "R5 oe-delimited read");
    step(0, 0, 1, 1, 1, 8'h44, "R5 held read no flip");
    step(0, 0, 1, 1, 1, 8'hFF, "R10 array ignored");
    step(1, 0, 1, 1, 1, 8'hFF, "R9 ce gap");
    step(0, 0, 1, 1, 1, 8'h00, "R5 ce-delimited read");
    step(1, 1, 1, 1, 1, 8'h00, "R9 gap");
    step(0, 0, 1, 1, 0, 8'hFF, "R4 polled bit 0 reads 1");
    step(1, 1, 1, 1, 0, 8'hFF, "R9 gap");
    step(0, 0, 1, 1, 0, 8'h00, "R6 low bits zero");
    // busy ends during held read
    step(0, 0, 1, 0, 0, 8'hC3, "R7 true data after busy");
    step(1, 1, 1, 0, 0, 8'hC3, "R9 gap");
    step(0, 0, 1, 0, 0, 8'h96, "R7 idle read");
    step(1, 1, 1, 0, 0, 8'h96, "R9 gap");
    step(0, 0, 1, 0, 0, 8'h69, "R7 idle read no toggle");
    step(1, 1, 1, 1, 1, 8'h69, "R9 busy two");
    // busy period 2 continues from the leftover toggle value
    step(0, 0, 1, 1, 1, 8'h69, "R8 toggle resumes");
    step(1, 1, 1, 1, 1, 8'h69, "R9 gap");
    step(0, 0, 1, 1, 1, 8'h69, "R8 R5 second read");
    step(1, 1, 1, 0, 1, 8'h69, "R9 end");
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule